// File: doc/BRIEF.md
# Shift-Register Hardware Stack

This block is a last-in first-out store for a small stack-machine processor. The storage is a chain of word-wide registers built in logic, with no memory macro and no pointer. The entry at the head of the chain is the top of the stack. It drives the output straight from its register, so no address decoding is needed to read it.

A push loads the write word into the head and moves every other word one place deeper. A pop moves every word one place toward the head. Asserting push and pop together overwrites only the head. Every operation completes on one clock edge.

The same module serves as the data stack (15 entries by default) and as the return stack (17 entries), set through the depth parameter. The design keeps no count of how many entries are live. For that reason it cannot detect overflow or underflow.

Top module: `shreg_stack`

## Requirements
- R1: After the active-low reset is released, every entry holds zero, so `top_o` reads 0 until the first push or replace.
- R2: With `push_i`=1 and `pop_i`=0 at a rising edge, `top_o` shows the `wdata_i` sampled at that edge from then on, with no extra latency.
- R3: A push moves entry k into entry k+1 for every k, and the deepest entry's old value is lost. After DEPTH+1 pushes, the first word pushed can no longer be reached by popping.
- R4: With `pop_i`=1 and `push_i`=0 at a rising edge, `top_o` then shows the word that was second from the top before the edge.
- R5: A pop leaves the deepest entry unchanged. Popping more times than words were pushed therefore keeps returning the deepest value.
- R6: With `push_i`=1 and `pop_i`=1 together, only the top entry is overwritten with `wdata_i`, and all deeper entries keep their values.
- R7: With both strobes at 0, no entry changes and `top_o` is stable.
- R8: WIDTH and DEPTH are parameters. Any DEPTH of 2 or more behaves as above, and instances of different depth fed the same stimulus each follow their own depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, clears every entry |
| push_i | input | 1 | Push strobe (replaces the top entry when given with pop_i) |
| pop_i | input | 1 | Pop strobe |
| wdata_i | input | WIDTH | Word to push or to replace the top with |
| top_o | output | WIDTH | Current top entry, read straight from the head register |

## Verification
The bench builds two instances at WIDTH 16, both driven by the same stimulus:
- A 4-deep instance, where a handful of pushes is enough to discard the deepest word and a few pops are enough to reach the repeated-bottom behaviour.
- A 17-deep instance, the return-stack size, which shows that the identical sequence gives a different result once the depth changes.

Directed sequences of push, pop, replace and idle cycles come first, followed by a long random mix. Each instance is compared against its own queue model after every edge.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_PUSH    = 2'd1,
        OP_POP     = 2'd2,
        OP_REPLACE = 2'd3
    } stk_op_e;
endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
    import stk_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    output stk_op_e op_o
);
    always_comb begin
        unique case ({push_i, pop_i})
            2'b10:   op_o = OP_PUSH;
            2'b01:   op_o = OP_POP;
            2'b11:   op_o = OP_REPLACE;
            default: op_o = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/stk_cell.sv
module stk_cell
    import stk_pkg::*;
#(
    parameter int  WIDTH  = 16,
    parameter bit  IS_TOP = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op_i,
    input  logic [WIDTH-1:0] above_i,
    input  logic [WIDTH-1:0] below_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] nxt;

    // Next value of this entry for each operation
    always_comb begin
        unique case (op_i)
            OP_PUSH:    nxt = above_i;
            OP_POP:     nxt = below_i;
            OP_REPLACE: nxt = IS_TOP ? above_i : q_o;
            default:    nxt = q_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= nxt;
    end
endmodule

// File: rtl/shreg_stack.sv
module shreg_stack
    import stk_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] top_o
);
    localparam int LAST = DEPTH - 1;

    stk_op_e                      op;
    logic [DEPTH-1:0][WIDTH-1:0]  ent;

    stk_op_decode i_dec (
        .push_i (push_i),
        .pop_i  (pop_i),
        .op_o   (op)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [WIDTH-1:0] above;
        logic [WIDTH-1:0] below;

        if (i == 0) begin : g_head
            assign above = wdata_i;
        end else begin : g_mid_a
            assign above = ent[i-1];
        end

        if (i == LAST) begin : g_tail
            assign below = ent[i];
        end else begin : g_mid_b
            assign below = ent[i+1];
        end

        stk_cell #(.WIDTH(WIDTH), .IS_TOP(i == 0)) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_i    (op),
            .above_i (above),
            .below_i (below),
            .q_o     (ent[i])
        );
    end

    assign top_o = ent[0];
endmodule

// File: rtl/shreg_stack_chk.sv
module shreg_stack_chk #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 15
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     push_i,
    input logic                     pop_i,
    input logic [WIDTH-1:0]         wdata_i,
    input logic [WIDTH-1:0]         top_o,
    input logic [DEPTH-1:0][WIDTH-1:0] ent
);
    logic in_rst_q;

    always_ff @(posedge clk) begin
        in_rst_q <= !rst_n;
        if (rst_n && in_rst_q) begin
            AST_RESET_ZERO: assert (top_o == '0); // R1
        end
    end

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> top_o == $past(wdata_i)); // R2

    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> ent[1] == $past(ent[0])); // R3

    AST_POP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> top_o == $past(ent[1])); // R4

    AST_POP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> $stable(ent[DEPTH-1])); // R5

    AST_REPLACE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> top_o == $past(wdata_i)); // R6

    AST_REPLACE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(ent[DEPTH-1:1])); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(ent)); // R7
endmodule

bind shreg_stack shreg_stack_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .wdata_i (wdata_i),
    .top_o   (top_o),
    .ent     (ent)
);

// File: tb/test_shreg_stack.sv
module test_shreg_stack;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 16;
    localparam int D_A   = 4;
    localparam int D_B   = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push = 1'b0;
    logic         pop = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] top_a;
    logic [W-1:0] top_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [W-1:0] mdl_a[$];
    logic [W-1:0] mdl_b[$];
    logic [W-1:0] exp_a[$];
    logic [W-1:0] exp_b[$];
    string        tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    shreg_stack #(.WIDTH(W), .DEPTH(D_A)) i_shreg_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .wdata_i(wdata), .top_o(top_a)
    );

    shreg_stack #(.WIDTH(W), .DEPTH(D_B)) i_shreg_stack_deep (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .wdata_i(wdata), .top_o(top_b)
    );

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: top=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: front of queue is the top entry
    task automatic model_step(bit ps, bit pp, logic [W-1:0] d);
        logic [W-1:0] last;
        if (ps && pp) begin
            mdl_a[0] = d;
            mdl_b[0] = d;
        end else if (ps) begin
            mdl_a.push_front(d); void'(mdl_a.pop_back());
            mdl_b.push_front(d); void'(mdl_b.pop_back());
        end else if (pp) begin
            last = mdl_a[$]; void'(mdl_a.pop_front()); mdl_a.push_back(last);
            last = mdl_b[$]; void'(mdl_b.pop_front()); mdl_b.push_back(last);
        end
    endtask

    // Driver: applies one operation and records the expectation
    task automatic drive(bit ps, bit pp, logic [W-1:0] d, string tag);
        @(negedge clk);
        push  = ps;
        pop   = pp;
        wdata = d;
        model_step(ps, pp, d);
        exp_a.push_back(mdl_a[0]);
        exp_b.push_back(mdl_b[0]);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares just after each edge
    always @(posedge clk) begin
        #1;
        if (exp_a.size() > 0) begin
            string t;
            t = tag_q.pop_front();
            check({t, " depth4"},  top_a, exp_a.pop_front());
            check({t, " depth17"}, top_b, exp_b.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < D_A; i++) mdl_a.push_back('0);
        for (int i = 0; i < D_B; i++) mdl_b.push_back('0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset top depth4",  top_a, '0);
        check("R1 reset top depth17", top_b, '0);

        // R2/R3: five pushes into a 4-deep stack lose the first word
        for (int i = 1; i <= 5; i++) drive(1, 0, W'(16'h1100 + i), "R2 push");
        drive(0, 0, '0, "R7 idle");
        drive(0, 0, 16'hDEAD, "R7 idle data ignored");
        // R4: pops expose older words
        for (int i = 0; i < 3; i++) drive(0, 1, '0, "R4 pop");
        // R3/R5: word 1 is gone, bottom word repeats
        for (int i = 0; i < 3; i++) drive(0, 1, '0, "R3 R5 pop past depth");
        // R6: replace only changes the top
        drive(1, 0, 16'hA0A0, "R2 push");
        drive(1, 0, 16'hB0B0, "R2 push");
        drive(1, 1, 16'hC0C0, "R6 replace");
        drive(0, 1, '0, "R6 deeper word kept");
        drive(0, 1, '0, "R6 pop after replace");
        drive(1, 1, 16'h7FFF, "R6 replace");
        drive(0, 0, '0, "R7 idle after replace");

        // R8: random mix, both depths against their models
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 3));
            drive(r[0], r[1], W'($urandom), "R8 random");
        end
        drive(0, 0, '0, "R7 idle");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule